// File: doc/BRIEF.md
# Glow Display Cathode/Anode Scanner

This block drives a multiplexed glow-discharge display. It enables one cathode position at a time. For each cathode it drives a short anode pulse whose bit pattern comes from a frame buffer, indexed by that cathode's number. The time spent on each cathode is set in clock cycles, so that a full pass over all cathodes repeats in the few-hundred-hertz to kilohertz range. The anode pulse length sets the brightness, and a hard ceiling of 12 microseconds is enforced on it.

Each cathode slot starts with a few blank cycles in which nothing is driven. During the last blank cycle the block reads the frame-buffer word for the coming cathode. The cathode is then enabled for the rest of the slot, and the anode pattern is driven from the start of the lit part for the requested number of cycles.

Configuration inputs are sampled only when a scan begins again at cathode 0, so one scan never mixes two settings.

Top module: `glow_scan_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, no cathode, anode or fetch output is active, and the first slot belongs to cathode 0.
- R2: At most one cathode enable is high at any time, and `cath_en[i]` is high only while `cath_idx` equals i. Slots visit the indices 0, 1, … NUM_CATH-1 in order and then wrap to 0, so each cathode is lit once per scan.
- R3: A slot lasts max(`cfg_slot`, BLANK+1) cycles, counted by a position that starts at 0. At positions below BLANK, no cathode and no anode is enabled. From position BLANK to the end of the slot, the cathode `cath_idx` is enabled.
- R4: The anode outputs carry the fetched pattern from position BLANK for P cycles and are zero otherwise. P = min(`cfg_pulse`, CAP, slot length − BLANK), so the pulse always lies inside the lit part of its slot.
- R5: CAP = (CLK_HZ / 1,000,000) × MAX_US cycles, with MAX_US = 12. No anode pulse is ever longer than CAP cycles, whatever width is requested.
- R6: `fb_rd_en` is high for exactly one cycle per slot, at position BLANK−1, with `fb_addr` equal to that slot's cathode index. The anode pattern is `fb_data` as sampled on that cycle. Changes to `fb_data` at any other time have no effect on the anodes.
- R7: `cfg_slot` and `cfg_pulse` are sampled on the first cycle after reset and on the last cycle of cathode NUM_CATH−1's slot. They apply from the next slot onward. A change at any other time does not alter the slot in progress or the rest of that scan.
- R8: A requested pulse width of 0 keeps every anode output low for the whole scan, while the cathodes still step through their slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_slot | input | SLOT_W | Requested cycles per cathode slot, blanking included |
| cfg_pulse | input | SLOT_W | Requested anode pulse width in cycles |
| fb_rd_en | output | 1 | Frame-buffer read strobe |
| fb_addr | output | IDX_W | Frame-buffer address (cathode index) |
| fb_data | input | ANODES | Frame-buffer word, combinational response to `fb_addr` |
| cath_en | output | NUM_CATH | One-hot cathode enables |
| cath_idx | output | IDX_W | Index of the current slot's cathode |
| anode_en | output | ANODES | Anode enables |

## Verification
The hardest case to reach is a configuration change that lands in the middle of a scan. It must stay invisible until cathode 0 comes round again, while the pulse clamp to both the ceiling and the lit slot length is exercised at its edges. The stimulus sweeps slot lengths from the minimum (BLANK+1) upward and pulse requests of zero, one, exactly the ceiling and beyond it. Each new setting is written at an arbitrary cycle, without waiting for a scan boundary. The frame-buffer contents are rewritten on every cycle, so a pattern latched on the wrong cycle shows up at once. A directed run changes the slot length during cathode 1 and times the slots that follow.

// File: rtl/glow_scan_pkg.sv
package glow_scan_pkg;

  // anode pulse ceiling in clock cycles for a given clock rate and limit in microseconds
  function automatic int unsigned cap_cycles(input int unsigned clk_hz, input int unsigned max_us);
    return (clk_hz / 32'd1_000_000) * max_us;
  endfunction

  // slot length actually used: at least one lit cycle after blanking
  function automatic int unsigned eff_slot_len(input int unsigned req, input int unsigned blank);
    return (req > blank) ? req : blank + 32'd1;
  endfunction

  // pulse width actually used: bounded by the ceiling and by the lit part of the slot
  function automatic int unsigned eff_pulse_len(input int unsigned req, input int unsigned slot,
                                                input int unsigned blank, input int unsigned cap);
    int unsigned lim;
    lim = slot - blank;
    if (cap < lim) lim = cap;
    return (req < lim) ? req : lim;
  endfunction

endpackage

// File: rtl/glow_scan_seq.sv
module glow_scan_seq
  import glow_scan_pkg::*;
#(
  parameter int unsigned NUM_CATH = 64,
  parameter int unsigned SLOT_W   = 16,
  parameter int unsigned BLANK    = 4,
  parameter int unsigned CAP      = 2400,
  localparam int unsigned IDX_W   = $clog2(NUM_CATH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [SLOT_W-1:0] cfg_pulse,
  output logic [SLOT_W-1:0] pos,
  output logic [IDX_W-1:0]  idx,
  output logic [SLOT_W-1:0] eff_slot,
  output logic [SLOT_W-1:0] eff_pulse,
  output logic              loaded,
  output logic              slot_wrap,
  output logic              frame_load
);

  logic              last_idx;
  logic [SLOT_W-1:0] nxt_slot;
  logic [SLOT_W-1:0] nxt_pulse;

  assign slot_wrap  = loaded && (pos == eff_slot - 1'b1);
  assign last_idx   = (idx == IDX_W'(NUM_CATH - 1));
  assign frame_load = !loaded || (slot_wrap && last_idx);

  always_comb begin
    nxt_slot  = SLOT_W'(eff_slot_len(32'(cfg_slot), BLANK));
    nxt_pulse = SLOT_W'(eff_pulse_len(32'(cfg_pulse), 32'(nxt_slot), BLANK, CAP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos       <= '0;
      idx       <= '0;
      eff_slot  <= '0;
      eff_pulse <= '0;
      loaded    <= 1'b0;
    end else begin
      if (frame_load) begin
        eff_slot  <= nxt_slot;
        eff_pulse <= nxt_pulse;
        loaded    <= 1'b1;
      end
      if (slot_wrap) begin
        pos <= '0;
        idx <= last_idx ? '0 : idx + 1'b1;
      end else if (loaded) begin
        pos <= pos + 1'b1;
      end
    end
  end

endmodule

// File: rtl/glow_scan_anode.sv
module glow_scan_anode #(
  parameter int unsigned ANODES   = 8,
  parameter int unsigned SLOT_W   = 16,
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned BLANK    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loaded,
  input  logic [SLOT_W-1:0] pos,
  input  logic [IDX_W-1:0]  idx,
  input  logic [SLOT_W-1:0] eff_pulse,
  input  logic [ANODES-1:0] fb_data,
  output logic              fb_rd_en,
  output logic [IDX_W-1:0]  fb_addr,
  output logic              pulse_on,
  output logic [ANODES-1:0] anode_en
);

  logic [ANODES-1:0] pattern;
  logic              lit_part;

  assign fb_rd_en = loaded && (pos == SLOT_W'(BLANK - 1));
  assign fb_addr  = idx;
  assign lit_part = (pos >= SLOT_W'(BLANK));
  assign pulse_on = lit_part && ((pos - SLOT_W'(BLANK)) < eff_pulse);
  assign anode_en = pulse_on ? pattern : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pattern <= '0;
    else if (fb_rd_en) pattern <= fb_data;
  end

endmodule

// File: rtl/glow_scan_cathode.sv
module glow_scan_cathode #(
  parameter int unsigned NUM_CATH = 64,
  parameter int unsigned SLOT_W   = 16,
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned BLANK    = 4
) (
  input  logic [SLOT_W-1:0]   pos,
  input  logic [IDX_W-1:0]    idx,
  output logic [NUM_CATH-1:0] cath_en
);

  logic lit_part;
  assign lit_part = (pos >= SLOT_W'(BLANK));

  for (genvar i = 0; i < NUM_CATH; i++) begin : g_cath
    assign cath_en[i] = lit_part && (idx == IDX_W'(i));
  end

endmodule

// File: rtl/glow_scan_top.sv
module glow_scan_top
  import glow_scan_pkg::*;
#(
  parameter int unsigned NUM_CATH = 64,
  parameter int unsigned ANODES   = 8,
  parameter int unsigned SLOT_W   = 16,
  parameter int unsigned BLANK    = 4,
  parameter int unsigned CLK_HZ   = 200_000_000,
  parameter int unsigned MAX_US   = 12,
  localparam int unsigned IDX_W   = $clog2(NUM_CATH),
  localparam int unsigned CAP     = cap_cycles(CLK_HZ, MAX_US)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOT_W-1:0]   cfg_slot,
  input  logic [SLOT_W-1:0]   cfg_pulse,
  output logic                fb_rd_en,
  output logic [IDX_W-1:0]    fb_addr,
  input  logic [ANODES-1:0]   fb_data,
  output logic [NUM_CATH-1:0] cath_en,
  output logic [IDX_W-1:0]    cath_idx,
  output logic [ANODES-1:0]   anode_en
);

  logic [SLOT_W-1:0] pos;
  logic [IDX_W-1:0]  idx;
  logic [SLOT_W-1:0] eff_slot;
  logic [SLOT_W-1:0] eff_pulse;
  logic              loaded;
  logic              slot_wrap;
  logic              frame_load;
  logic              pulse_on;

  glow_scan_seq #(.NUM_CATH(NUM_CATH), .SLOT_W(SLOT_W), .BLANK(BLANK), .CAP(CAP)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_slot(cfg_slot), .cfg_pulse(cfg_pulse),
    .pos(pos), .idx(idx), .eff_slot(eff_slot), .eff_pulse(eff_pulse),
    .loaded(loaded), .slot_wrap(slot_wrap), .frame_load(frame_load)
  );

  glow_scan_anode #(.ANODES(ANODES), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .BLANK(BLANK)) u_anode (
    .clk(clk), .rst_n(rst_n), .loaded(loaded), .pos(pos), .idx(idx),
    .eff_pulse(eff_pulse), .fb_data(fb_data), .fb_rd_en(fb_rd_en),
    .fb_addr(fb_addr), .pulse_on(pulse_on), .anode_en(anode_en)
  );

  glow_scan_cathode #(.NUM_CATH(NUM_CATH), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .BLANK(BLANK)) u_cath (
    .pos(pos), .idx(idx), .cath_en(cath_en)
  );

  assign cath_idx = idx;

endmodule

// File: rtl/glow_scan_chk.sv
module glow_scan_chk
  import glow_scan_pkg::*;
#(
  parameter int unsigned NUM_CATH = 64,
  parameter int unsigned ANODES   = 8,
  parameter int unsigned SLOT_W   = 16,
  parameter int unsigned CLK_HZ   = 200_000_000,
  parameter int unsigned MAX_US   = 12,
  localparam int unsigned IDX_W   = $clog2(NUM_CATH),
  localparam int unsigned CAP     = cap_cycles(CLK_HZ, MAX_US)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_CATH-1:0] cath_en,
  input logic [IDX_W-1:0]    cath_idx,
  input logic [ANODES-1:0]   anode_en,
  input logic                fb_rd_en,
  input logic                pulse_on,
  input logic                slot_wrap,
  input logic                frame_load,
  input logic [SLOT_W-1:0]   eff_slot,
  input logic [SLOT_W-1:0]   eff_pulse
);

  int unsigned run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else        run_len <= pulse_on ? run_len + 1 : 0;
  end

  a_r1_idle_in_reset: assert property (@(posedge clk)
    !rst_n |-> (cath_en == '0 && anode_en == '0 && !fb_rd_en));

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cath_en));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wrap |=> cath_idx == (($past(cath_idx) == IDX_W'(NUM_CATH - 1)) ? '0 : $past(cath_idx) + 1'b1));

  a_r3_fetch_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd_en |-> (cath_en == '0 && anode_en == '0));

  a_r4_anode_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_on || anode_en != '0) |-> cath_en != '0);

  a_r5_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= CAP);

  a_r6_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cath_en != '0) |-> $past(fb_rd_en));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> ($stable(eff_slot) && $stable(eff_pulse)));

endmodule

bind glow_scan_top glow_scan_chk #(
  .NUM_CATH(NUM_CATH), .ANODES(ANODES), .SLOT_W(SLOT_W), .CLK_HZ(CLK_HZ), .MAX_US(MAX_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cath_en(cath_en), .cath_idx(cath_idx), .anode_en(anode_en),
  .fb_rd_en(fb_rd_en), .pulse_on(pulse_on), .slot_wrap(slot_wrap),
  .frame_load(frame_load), .eff_slot(eff_slot), .eff_pulse(eff_pulse)
);

// File: tb/glow_scan_top_test.sv
`timescale 1ns/1ps
module glow_scan_top_test;
  localparam int N   = 4;
  localparam int AN  = 4;
  localparam int SW  = 8;
  localparam int BL  = 2;
  localparam int HZ  = 1_000_000;
  localparam int LIM = 12;          // ceiling in cycles: 1 cycle/us * 12 us
  localparam int IW  = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [SW-1:0] cfg_slot, cfg_pulse;
  logic          fb_rd_en;
  logic [IW-1:0] fb_addr;
  logic [AN-1:0] fb_data;
  logic [N-1:0]  cath_en;
  logic [IW-1:0] cath_idx;
  logic [AN-1:0] anode_en;
  logic [AN-1:0] fbmem [N];

  assign fb_data = fbmem[fb_addr];

  glow_scan_top #(.NUM_CATH(N), .ANODES(AN), .SLOT_W(SW), .BLANK(BL), .CLK_HZ(HZ), .MAX_US(12)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_slot(cfg_slot), .cfg_pulse(cfg_pulse),
    .fb_rd_en(fb_rd_en), .fb_addr(fb_addr), .fb_data(fb_data),
    .cath_en(cath_en), .cath_idx(cath_idx), .anode_en(anode_en)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit live = 0;
  int run = 0, maxrun = 0, lit_cnt = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int want_slot(input int r);
    if (r <= BL) return BL + 1;
    return r;
  endfunction

  function automatic int want_pulse(input int r, input int s);
    int w;
    w = r;
    if (w > LIM) w = LIM;
    if (w > s - BL) w = s - BL;
    return w;
  endfunction

  // reference timeline kept from the requirements
  bit m_on; int m_pos, m_idx, m_slot, m_pul; logic [AN-1:0] m_pat;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_on <= 0; m_pos <= 0; m_idx <= 0; m_slot <= 0; m_pul <= 0; m_pat <= '0;
    end else if (!m_on) begin
      m_on <= 1; m_slot <= want_slot(cfg_slot);
      m_pul <= want_pulse(cfg_pulse, want_slot(cfg_slot));
    end else begin
      if (m_pos == BL - 1) m_pat <= fbmem[m_idx];
      if (m_pos + 1 == m_slot) begin
        m_pos <= 0;
        m_idx <= (m_idx + 1) % N;
        if (m_idx == N - 1) begin
          m_slot <= want_slot(cfg_slot);
          m_pul  <= want_pulse(cfg_pulse, want_slot(cfg_slot));
        end
      end else m_pos <= m_pos + 1;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (live) begin
      logic [N-1:0] ec; logic [AN-1:0] ea; bit er;
      ec = (m_pos >= BL) ? (N'(1) << m_idx) : '0;
      ea = (m_pos >= BL && m_pos < BL + m_pul) ? m_pat : '0;
      er = m_on && (m_pos == BL - 1);
      chk(cath_en == ec, "R2 R3 cathode enables", cath_en, ec);
      chk(cath_idx == IW'(m_idx), "R2 slot index", cath_idx, m_idx);
      chk(anode_en == ea, "R4 R6 anode enables", anode_en, ea);
      chk(fb_rd_en == er, "R6 fetch strobe", fb_rd_en, er);
      if (er) chk(fb_addr == IW'(m_idx), "R6 fetch address", fb_addr, m_idx);
      if (anode_en != '0) begin run++; lit_cnt++; end else run = 0;
      if (run > maxrun) maxrun = run;
    end
    for (int i = 0; i < N; i++) fbmem[i] = AN'((cyc * 3 + i * 7 + (cyc >> 3)) | (i == 0 ? 1 : 0));
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wait_idx(input int v);
    do @(negedge clk); while (cath_idx != IW'(v));
  endtask

  initial begin
    int slots [5] = '{0, 3, 5, 9, 20};
    int puls  [7] = '{0, 1, 3, 7, 12, 13, 30};
    int prev = 3;
    for (int i = 0; i < N; i++) fbmem[i] = '0;
    rst_n = 1'b0; cfg_slot = 8'd5; cfg_pulse = 8'd3;
    repeat (3) @(negedge clk);
    chk(cath_en == '0, "R1 cathodes idle in reset", cath_en, 0);
    chk(anode_en == '0, "R1 anodes idle in reset", anode_en, 0);
    chk(!fb_rd_en, "R1 no fetch in reset", fb_rd_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cath_idx == '0, "R1 first slot is cathode 0", cath_idx, 0);
    chk(cath_en == '0 && anode_en == '0, "R1 idle after reset", cath_en, 0);
    live = 1;
    // sweep: settings change at arbitrary cycles, the timeline applies them at scan start (R7)
    foreach (slots[s]) foreach (puls[p]) begin
      int w;
      cfg_slot = SW'(slots[s]); cfg_pulse = SW'(puls[p]);
      w = want_slot(slots[s] > prev ? slots[s] : prev);
      repeat (w * N * 3 + 1) @(negedge clk);
      prev = want_slot(slots[s]);
    end
    chk(maxrun == LIM, "R5 longest anode pulse equals ceiling", maxrun, LIM);
    // R8: zero width, no anode activity over two full scans
    cfg_slot = 8'd9; cfg_pulse = 8'd0;
    repeat (9 * N * 2) @(negedge clk);
    lit_cnt = 0;
    repeat (9 * N * 2) @(negedge clk);
    chk(lit_cnt == 0, "R8 zero width keeps anodes dark", lit_cnt, 0);
    // R7: change slot length during cathode 1, measure following slots
    cfg_pulse = 8'd3;
    repeat (9 * N * 2) @(negedge clk);
    wait_idx(1);
    cfg_slot = 8'd20;
    begin
      int len;
      wait_idx(2);
      len = 0;
      while (cath_idx == IW'(2)) begin len++; @(negedge clk); end
      chk(len == 9, "R7 R3 slot keeps old length mid scan", len, 9);
      wait_idx(0);
      len = 0;
      while (cath_idx == IW'(0)) begin len++; @(negedge clk); end
      chk(len == 20, "R7 R3 new length from cathode 0", len, 20);
    end
    // R5: oversized request inside a long slot is clamped
    cfg_slot = 8'd40; cfg_pulse = 8'd50; maxrun = 0;
    repeat (40 * N * 3) @(negedge clk);
    chk(maxrun == LIM, "R5 oversized request clamped", maxrun, LIM);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule